// File: doc/BRIEF.md
# Page Write Collector with Quarter-Array Protection

This block sits between a two-wire serial bus engine and a nonvolatile memory array. Once the bus engine has decoded a write command, it passes the block a start address and then one strobe per received data byte. The block gathers these bytes in a 32-byte page buffer. When the bus engine reports a Stop, the block runs a self-timed programming cycle that commits the gathered bytes to the array through a simple write port. While that cycle runs, the block raises a busy flag. The bus engine uses this flag to withhold acknowledges, which gives the host its usual acknowledge-polling behaviour.

A write-protect input guards the top quarter of the 13-bit address space (addresses 1800h to 1FFFh). The block samples this input only in the cycle in which the Stop is reported. A protected write is still acknowledged on the bus, but its bytes are dropped and no busy period follows.

The controller has three states:
- IDLE waits for a Start.
- FILL is entered on a Start and accepts an address load and data bytes.
- PROG is the busy programming cycle.

Its transitions are:
- IDLE→FILL on a Start.
- FILL→FILL on a repeated Start, which empties the buffer.
- FILL→PROG on a Stop when the buffer holds data and the page is not protected.
- FILL→IDLE on a Stop that finds an empty buffer or a protected page.
- PROG→IDLE on the last count of the write time.

Top module: `pwb_top`

## Requirements
- R1: During and after reset, `busy_o` and `arr_we_o` are low.
- R2: Each accepted byte goes to the current page offset, and only the low five address bits advance after it. A run that passes offset 31 continues at offset 0 of the same page, and the upper address bits never change.
- R3: If more than 32 bytes arrive before the Stop, a later byte replaces the earlier one at the same offset. Only the last value written to each offset is committed.
- R4: Nothing is written to the array before the Stop. `busy_o` rises in the first cycle after the cycle in which `stop_i` is sampled.
- R5: A committing write keeps `busy_o` high for exactly `WR_CYCLES` cycles.
- R6: Only offsets loaded since the most recent Start are written. They are written in ascending offset order, one per cycle, in the first 32 busy cycles. A repeated Start discards bytes loaded earlier.
- R7: If `wp_i` is high at the Stop and the page lies in 1800h–1FFFh, no array write occurs and `busy_o` stays low.
- R8: With `wp_i` low, a page in the protected quarter is written normally. Pages below 1800h are written whatever the level of `wp_i`.
- R9: A change of `wp_i` after the Stop cycle has no effect on a programming cycle already under way.
- R10: While `busy_o` is high, `start_i`, `addr_ld_i`, `byte_vld_i` and `stop_i` are ignored. The buffer, the write sequence and the busy length are left unchanged.
- R11: A Stop with no data byte loaded since the Start (for example a read or an address-only transfer) starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse: Start condition seen |
| stop_i | input | 1 | One-cycle pulse: Stop condition seen |
| addr_ld_i | input | 1 | Load the start address from `addr_i` |
| addr_i | input | ADDR_W | Start word address |
| byte_vld_i | input | 1 | One received data byte is on `byte_i` |
| byte_i | input | 8 | Received data byte |
| wp_i | input | 1 | Write-protect level, sampled at Stop |
| busy_o | output | 1 | Programming cycle in progress |
| arr_we_o | output | 1 | Array write strobe |
| arr_addr_o | output | ADDR_W | Array write address |
| arr_data_o | output | 8 | Array write data |

## Verification
A bus event can coincide with the programming cycle: the host may send a new Start, an address, data and a Stop while `busy_o` is high. The bench provokes this by injecting a full write transaction a few cycles into a busy period. It then judges that the write count, the busy length and an untouched array location are exactly as for an undisturbed commit. Write protection and the Stop also share a cycle. For that case the bench drives `wp_i` to one level in the Stop cycle and to the opposite level in the following cycle, and checks that only the Stop-cycle level decides the outcome.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_PROG = 2'd2
    } pwb_state_e;
endpackage

// File: rtl/pwb_pagebuf.sv
module pwb_pagebuf #(
    parameter int PAGE_BYTES = 32,
    parameter int OFS_W      = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             ld_i,
    input  logic [OFS_W-1:0] ofs_i,
    input  logic             wr_i,
    input  logic [7:0]       data_i,
    input  logic             hold_i,
    input  logic [OFS_W-1:0] rd_idx_i,
    output logic [7:0]       rd_data_o,
    output logic             rd_vld_o,
    output logic             any_vld_o
);
    localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(PAGE_BYTES - 1);

    logic [OFS_W-1:0]      ptr_q;
    logic [PAGE_BYTES-1:0] mask_q;
    logic [7:0]            mem_q [PAGE_BYTES];

    // write pointer: address load wins, else advance (wraps in page)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ptr_q <= '0;
        else if (ld_i) ptr_q <= ofs_i;
        else if (wr_i) ptr_q <= ptr_q + 1'b1;
    end

    genvar g;
    generate
        for (g = 0; g < PAGE_BYTES; g++) begin : g_entry
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    mask_q[g] <= 1'b0;
                else if (clr_i)
                    mask_q[g] <= 1'b0;
                else if (wr_i && !ld_i && ptr_q == OFS_W'(g))
                    mask_q[g] <= 1'b1;
            end
            always_ff @(posedge clk) begin
                if (wr_i && !ld_i && !clr_i && ptr_q == OFS_W'(g))
                    mem_q[g] <= data_i;
            end
        end
    endgenerate

    assign rd_data_o = mem_q[rd_idx_i];
    assign rd_vld_o  = mask_q[rd_idx_i];
    assign any_vld_o = |mask_q;

    // R2: pointer wraps to offset 0 inside the page
    p_ptr_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !ld_i && ptr_q == LAST_OFS) |=> (ptr_q == '0));

    // R10: valid mask frozen while programming
    p_mask_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !clr_i) |=> $stable(mask_q));
endmodule

// File: rtl/pwb_prot.sv
module pwb_prot #(
    parameter int PAGE_W = 8
) (
    input  logic [PAGE_W-1:0] page_i,
    input  logic              wp_i,
    output logic              hit_o
);
    // top quarter of the array: two most significant address bits set
    assign hit_o = wp_i && (&page_i[PAGE_W-1 -: 2]);
endmodule

// File: rtl/pwb_timer.sv
module pwb_timer #(
    parameter int WR_CYCLES = 200000,
    parameter int CNT_W     = $clog2(WR_CYCLES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic             en_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             last_o
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WR_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (go_i)                    cnt_q <= '0;
        else if (en_i && cnt_q != LAST_CNT) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o  = cnt_q;
    assign last_o = en_i && (cnt_q == LAST_CNT);
endmodule

// File: rtl/pwb_top.sv
module pwb_top
    import pwb_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int PAGE_BYTES = 32,
    parameter int WR_CYCLES  = 200000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              addr_ld_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              byte_vld_i,
    input  logic [7:0]        byte_i,
    input  logic              wp_i,
    output logic              busy_o,
    output logic              arr_we_o,
    output logic [ADDR_W-1:0] arr_addr_o,
    output logic [7:0]        arr_data_o
);
    localparam int OFS_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFS_W;
    localparam int CNT_W  = $clog2(WR_CYCLES);
    localparam logic [CNT_W-1:0] WIN_END = CNT_W'(PAGE_BYTES);

    pwb_state_e        state_q, state_d;
    logic [PAGE_W-1:0] page_q;
    logic              in_fill, in_prog, accept;
    logic              buf_clr, buf_ld, buf_wr;
    logic              stop_hit, go_prog, prot_hit;
    logic              any_vld, rd_vld, tmr_last;
    logic [7:0]        rd_data;
    logic [CNT_W-1:0]  tmr_cnt;
    logic [OFS_W-1:0]  slot;

    assign in_fill  = (state_q == ST_FILL);
    assign in_prog  = (state_q == ST_PROG);
    assign accept   = !in_prog;
    assign buf_ld   = in_fill && addr_ld_i;
    assign buf_wr   = in_fill && byte_vld_i;
    assign stop_hit = in_fill && stop_i;
    assign go_prog  = stop_hit && any_vld && !prot_hit;
    assign buf_clr  = (accept && start_i) || tmr_last || (stop_hit && !go_prog);
    assign slot     = tmr_cnt[OFS_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      page_q <= '0;
        else if (buf_ld) page_q <= addr_i[ADDR_W-1:OFS_W];
    end

    pwb_pagebuf #(.PAGE_BYTES(PAGE_BYTES), .OFS_W(OFS_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (buf_clr),
        .ld_i      (buf_ld),
        .ofs_i     (addr_i[OFS_W-1:0]),
        .wr_i      (buf_wr),
        .data_i    (byte_i),
        .hold_i    (in_prog),
        .rd_idx_i  (slot),
        .rd_data_o (rd_data),
        .rd_vld_o  (rd_vld),
        .any_vld_o (any_vld)
    );

    pwb_prot #(.PAGE_W(PAGE_W)) u_prot (
        .page_i (page_q),
        .wp_i   (wp_i),
        .hit_o  (prot_hit)
    );

    pwb_timer #(.WR_CYCLES(WR_CYCLES), .CNT_W(CNT_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (go_prog),
        .en_i   (in_prog),
        .cnt_o  (tmr_cnt),
        .last_o (tmr_last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_FILL;
            ST_FILL: begin
                if (stop_i)       state_d = go_prog ? ST_PROG : ST_IDLE;
                else if (start_i) state_d = ST_FILL;
            end
            ST_PROG: if (tmr_last) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        busy_o     = in_prog;
        arr_we_o   = in_prog && (tmr_cnt < WIN_END) && rd_vld;
        arr_addr_o = {page_q, slot};
        arr_data_o = rd_data;
    end

    // R4: busy only ever rises right after a reported Stop
    p_rise_after_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(stop_i));

    // R7: protected page with WP high at Stop never enters programming
    p_prot_discard_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fill && stop_i && wp_i && (&page_q[PAGE_W-1 -: 2])) |=> !busy_o);

    // R10: a Start during programming does not end the busy period
    p_start_keeps_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !tmr_last) |=> busy_o);

    // R1: no array write outside programming
    p_no_idle_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_PROG) |-> !arr_we_o);
endmodule

// File: tb/tb_pwb_top.sv
module tb_pwb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WR         = 40;
    localparam int NVEC       = 8;

    typedef struct packed {
        logic [12:0] addr;
        logic [6:0]  n;
        logic        wp;
        logic        commit;
    } vec_t;

    // addr, bytes, wp at Stop, commit expected
    localparam vec_t VEC [NVEC] = '{
        '{13'h0010, 7'd1,  1'b0, 1'b1},   // R8 single byte, low page
        '{13'h003C, 7'd8,  1'b0, 1'b1},   // R2 wrap inside page
        '{13'h0100, 7'd40, 1'b0, 1'b1},   // R3 overwrite
        '{13'h1820, 7'd4,  1'b1, 1'b0},   // R7 protected, discarded
        '{13'h1840, 7'd4,  1'b0, 1'b1},   // R8 protected quarter, wp low
        '{13'h17E0, 7'd3,  1'b1, 1'b1},   // R8 just below quarter, wp high
        '{13'h1FFF, 7'd2,  1'b1, 1'b0},   // R7 top byte, wraps, discarded
        '{13'h0300, 7'd0,  1'b0, 1'b0}    // R11 no data bytes
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, stop_i = 1'b0, addr_ld_i = 1'b0, byte_vld_i = 1'b0, wp_i = 1'b0;
    logic [12:0] addr_i = '0;
    logic [7:0]  byte_i = '0;
    logic        busy_o, arr_we_o;
    logic [12:0] arr_addr_o;
    logic [7:0]  arr_data_o;

    int n_chk = 0, n_fail = 0;
    int wcount = 0, bcount = 0;
    logic [7:0] mem [8192];
    logic [7:0] exp_mem [8192];

    pwb_top #(.ADDR_W(13), .PAGE_BYTES(32), .WR_CYCLES(WR)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .addr_ld_i(addr_ld_i), .addr_i(addr_i), .byte_vld_i(byte_vld_i),
        .byte_i(byte_i), .wp_i(wp_i), .busy_o(busy_o), .arr_we_o(arr_we_o),
        .arr_addr_o(arr_addr_o), .arr_data_o(arr_data_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (rst_n && arr_we_o) begin
            mem[arr_addr_o] = arr_data_o;
            wcount++;
        end
        if (rst_n && busy_o) bcount++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_txn(input logic [12:0] a, input int n, input int seed,
                           input logic wp_stop, input logic wp_after,
                           input bit commit, input bit noise, input string req);
        int exp_w;
        int bad;
        wcount = 0;
        bcount = 0;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0; addr_ld_i = 1'b1; addr_i = a;
        @(negedge clk) addr_ld_i = 1'b0;
        for (int i = 0; i < n; i++) begin
            byte_vld_i = 1'b1;
            byte_i = 8'(seed + i);
            if (commit) exp_mem[{a[12:5], 5'(a[4:0] + 5'(i))}] = 8'(seed + i);
            @(negedge clk);
        end
        byte_vld_i = 1'b0;
        check(wcount == 0, {req, "/R4 no write before Stop"}, wcount, 0);
        wp_i = wp_stop;
        stop_i = 1'b1;
        @(negedge clk) stop_i = 1'b0;
        wp_i = wp_after;
        check(busy_o == commit, {req, "/R4 busy after Stop"}, busy_o, commit);
        if (noise) begin
            repeat (3) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk) start_i = 1'b0; addr_ld_i = 1'b1; addr_i = 13'h0400;
            @(negedge clk) addr_ld_i = 1'b0; byte_vld_i = 1'b1; byte_i = 8'h55;
            @(negedge clk) byte_vld_i = 1'b0; stop_i = 1'b1;
            @(negedge clk) stop_i = 1'b0;
        end
        repeat (WR + 6) @(negedge clk);
        exp_w = commit ? ((n > 32) ? 32 : n) : 0;
        check(bcount == (commit ? WR : 0), {req, "/R5 busy length"}, bcount, commit ? WR : 0);
        check(wcount == exp_w, {req, "/R6 write count"}, wcount, exp_w);
        bad = 0;
        for (int o = 0; o < 32; o++)
            if (mem[{a[12:5], 5'(o)}] !== exp_mem[{a[12:5], 5'(o)}]) bad++;
        check(bad == 0, {req, "/R2 R3 page contents"}, bad, 0);
        wp_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        check(1'b0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8192; i++) begin
            mem[i] = 8'h00;
            exp_mem[i] = 8'h00;
        end
        repeat (3) @(negedge clk);
        check(busy_o == 1'b0 && arr_we_o == 1'b0, "R1 in reset", {busy_o, arr_we_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy_o == 1'b0 && arr_we_o == 1'b0, "R1 after reset", {busy_o, arr_we_o}, 0);

        for (int v = 0; v < NVEC; v++)
            run_txn(VEC[v].addr, int'(VEC[v].n), v * 16 + 3, VEC[v].wp, VEC[v].wp,
                    VEC[v].commit, 1'b0, $sformatf("vec%0d", v));

        // R9: WP rises just after Stop, protected page still committed
        run_txn(13'h1A00, 3, 8'h90, 1'b0, 1'b1, 1'b1, 1'b0, "R9");
        // R7 counterpart: WP falls just after Stop, still discarded
        run_txn(13'h1A40, 3, 8'hA0, 1'b1, 1'b0, 1'b0, 1'b0, "R7 wp falls late");

        // R10: full transaction injected during busy
        run_txn(13'h0500, 6, 8'h30, 1'b0, 1'b0, 1'b1, 1'b1, "R10");
        check(mem[13'h0400] == 8'h00, "R10 noise write ignored", mem[13'h0400], 0);

        // R6: repeated Start discards earlier bytes
        wcount = 0;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0; addr_ld_i = 1'b1; addr_i = 13'h0200;
        @(negedge clk) addr_ld_i = 1'b0;
        for (int i = 0; i < 5; i++) begin
            byte_vld_i = 1'b1; byte_i = 8'(8'hA0 + i);
            @(negedge clk);
        end
        byte_vld_i = 1'b0; start_i = 1'b1;
        @(negedge clk) start_i = 1'b0; addr_ld_i = 1'b1; addr_i = 13'h020A;
        @(negedge clk) addr_ld_i = 1'b0; byte_vld_i = 1'b1; byte_i = 8'h11;
        @(negedge clk) byte_i = 8'h12;
        @(negedge clk) byte_vld_i = 1'b0; stop_i = 1'b1;
        @(negedge clk) stop_i = 1'b0;
        repeat (WR + 6) @(negedge clk);
        check(wcount == 2, "R6 only reloaded bytes written", wcount, 2);
        check(mem[13'h020A] == 8'h11 && mem[13'h020B] == 8'h12, "R6 new bytes",
              {mem[13'h020A], mem[13'h020B]}, 16'h1112);
        check(mem[13'h0200] == 8'h00, "R6 stale byte dropped", mem[13'h0200], 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule